// File: doc/BRIEF.md
# Receive-Priority Bus Arbiter

This block decides which of two DMA engines, receive or transmit, owns a shared system bus for its next burst, and how many words that burst may carry. It watches the fill level of the receive FIFO. When the FIFO gets too full, the receive engine is favoured so that incoming frames are not dropped. When that pressure is absent, the two engines take turns.

The receive-favour flag uses hysteresis. It turns on at a high watermark and turns off at a low watermark. Both watermarks are programmed in eighths of the FIFO depth, and a separate switch disables the mechanism entirely.

Each granted burst length is clipped by a burst-limit code. It can then be snapped to one of the fixed burst sizes that the bus side declares it supports. Once a burst is granted, the grant stays in place until the agreed number of beats has been transferred.

Top module: `rxpri_bus_arb`

## Requirements
- R1: During and right after synchronous reset, `gnt_rx`, `gnt_tx` and `rx_prio` are 0 and `gnt_len` is 0.
- R2: With `thr_en`=1, a clock edge that samples `fill_level` >= `hi_mark`*DEPTH/8 sets `rx_prio` (visible after that edge).
- R3: With `thr_en`=1, `rx_prio` clears at an edge that samples `fill_level` <= `lo_mark`*DEPTH/8 and below the high bound. Strictly between the bounds it keeps its value.
- R4: With `thr_en`=0, `rx_prio` is 0 after the next edge, and arbitration is plain round-robin.
- R5: When no burst is active, `rx_prio`=1 and `rx_req`=1, the next grant goes to receive, even if `tx_req`=1 and receive won last.
- R6: Without receive priority, simultaneous requests alternate between the engines. The first tie after reset goes to receive, and a lone requester is always served.
- R7: At most one grant is high. A grant appears one edge after an idle edge with a request. It stays high, unchanged, until `beat` has been sampled high `gnt_len` times, and `rx_prio` does not pre-empt it.
- R8: `burst_code` 0 and 1 leave the requested length unlimited, 2 caps it at 32 words, and 3 caps it at 64 words.
- R9: `burst_caps` bit0/bit1/bit2 declare sizes 4/8/16. If any bit is set, the granted length is the largest declared size not above the capped length, or 1 if none fits. If no bit is set, the granted length is the capped length.
- R10: A request length of 0 is granted as 1 beat. After the final beat the grant and `gnt_len` drop to 0 at that edge, and there is at least one idle cycle before the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_en | input | 1 | Enables receive-pressure priority |
| hi_mark | input | 3 | High watermark, in eighths of FIFO depth |
| lo_mark | input | 3 | Low watermark, in eighths of FIFO depth |
| fill_level | input | $clog2(DEPTH+1) | Receive FIFO occupancy in words |
| burst_code | input | 2 | Burst length limit code |
| burst_caps | input | SIZES | Supported fixed burst sizes (4, 8, 16) |
| rx_req | input | 1 | Receive DMA requests the bus |
| rx_len | input | LEN_W | Receive DMA requested length in words |
| tx_req | input | 1 | Transmit DMA requests the bus |
| tx_len | input | LEN_W | Transmit DMA requested length in words |
| beat | input | 1 | One word of the active burst transferred |
| gnt_rx | output | 1 | Bus granted to receive DMA |
| gnt_tx | output | 1 | Bus granted to transmit DMA |
| gnt_len | output | LEN_W | Permitted length of the granted burst, 0 when idle |
| rx_prio | output | 1 | Receive-pressure priority currently active |

## Verification
A corrupted hysteresis flag shows on `rx_prio` one edge after the fill level crosses a bound, and on the grant choice at the next tie. A wrong beat counter shows as a grant that drops early or lingers past the last beat. It is caught in the very cycle the expected release should appear. A bad round-robin pointer or length clip shows in the first grant that follows, because the bench sets up ties and known lengths with a single expected owner and length.

// File: rtl/rxpri_pkg.sv
package rxpri_pkg;
  typedef enum logic {OWN_TX = 1'b0, OWN_RX = 1'b1} owner_e;
  localparam logic [1:0] BC_FREE = 2'd0;
  localparam logic [1:0] BC_RSVD = 2'd1;
  localparam logic [1:0] BC_LIMA = 2'd2;
  localparam logic [1:0] BC_LIMB = 2'd3;
endpackage

// File: rtl/rxpri_watermark.sv
module rxpri_watermark #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       hi,
  input  logic [2:0]       lo,
  input  logic [LVL_W-1:0] fill,
  output logic             prio
);
  localparam int TH_W = LVL_W + 4;

  logic [TH_W-1:0] hi_thr, lo_thr, fill_x;

  always_comb begin
    hi_thr = (TH_W'(hi) * TH_W'(DEPTH)) >> 3;
    lo_thr = (TH_W'(lo) * TH_W'(DEPTH)) >> 3;
    fill_x = TH_W'(fill);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      prio <= 1'b0;
    end else if (fill_x >= hi_thr) begin
      prio <= 1'b1;
    end else if (fill_x <= lo_thr) begin
      prio <= 1'b0;
    end
  end
endmodule

// File: rtl/rxpri_len_cap.sv
module rxpri_len_cap
  import rxpri_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int SIZES = 3,
  parameter int LIM_A = 32,
  parameter int LIM_B = 64
) (
  input  logic [LEN_W-1:0] req_len,
  input  logic [1:0]       code,
  input  logic [SIZES-1:0] caps,
  output logic [LEN_W-1:0] out_len
);
  logic [LEN_W-1:0] nz_len, capped;

  always_comb begin
    nz_len = (req_len == '0) ? LEN_W'(1) : req_len;
    capped = nz_len;
    if (code == BC_LIMA && nz_len > LEN_W'(LIM_A)) capped = LEN_W'(LIM_A);
    if (code == BC_LIMB && nz_len > LEN_W'(LIM_B)) capped = LEN_W'(LIM_B);
  end

  always_comb begin
    if (caps == '0) begin
      out_len = capped;
    end else begin
      out_len = LEN_W'(1);
      for (int i = 0; i < SIZES; i++) begin
        if (caps[i] && (LEN_W'(4 << i) <= capped)) out_len = LEN_W'(4 << i);
      end
    end
  end
endmodule

// File: rtl/rxpri_grant.sv
module rxpri_grant
  import rxpri_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_prio,
  input  logic             rx_req,
  input  logic             tx_req,
  input  logic [LEN_W-1:0] rx_glen,
  input  logic [LEN_W-1:0] tx_glen,
  input  logic             beat,
  output logic             gnt_rx,
  output logic             gnt_tx,
  output logic [LEN_W-1:0] gnt_len
);
  logic             busy;
  owner_e           last_own;
  logic [LEN_W-1:0] remain;
  logic             pick_rx;

  always_comb begin
    pick_rx = rx_req && (rx_prio || !tx_req || (last_own == OWN_TX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      last_own <= OWN_TX;
      remain   <= '0;
      gnt_rx   <= 1'b0;
      gnt_tx   <= 1'b0;
      gnt_len  <= '0;
    end else if (!busy) begin
      if (rx_req || tx_req) begin
        busy     <= 1'b1;
        gnt_rx   <= pick_rx;
        gnt_tx   <= !pick_rx;
        gnt_len  <= pick_rx ? rx_glen : tx_glen;
        remain   <= pick_rx ? rx_glen : tx_glen;
        last_own <= pick_rx ? OWN_RX : OWN_TX;
      end
    end else if (beat) begin
      remain <= remain - 1'b1;
      if (remain == LEN_W'(1)) begin
        busy    <= 1'b0;
        gnt_rx  <= 1'b0;
        gnt_tx  <= 1'b0;
        gnt_len <= '0;
      end
    end
  end
endmodule

// File: rtl/rxpri_bus_arb.sv
module rxpri_bus_arb #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 11,
  parameter int SIZES = 3,
  parameter int LIM_A = 32,
  parameter int LIM_B = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             thr_en,
  input  logic [2:0]       hi_mark,
  input  logic [2:0]       lo_mark,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [1:0]       burst_code,
  input  logic [SIZES-1:0] burst_caps,
  input  logic             rx_req,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             tx_req,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             beat,
  output logic             gnt_rx,
  output logic             gnt_tx,
  output logic [LEN_W-1:0] gnt_len,
  output logic             rx_prio
);
  localparam int ENG = 2;

  logic [ENG-1:0][LEN_W-1:0] req_v, glen_v;

  assign req_v[1] = rx_len;
  assign req_v[0] = tx_len;

  rxpri_watermark #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_wm (
    .clk (clk), .rst (rst), .en (thr_en), .hi (hi_mark), .lo (lo_mark),
    .fill(fill_level), .prio(rx_prio)
  );

  for (genvar g = 0; g < ENG; g++) begin : g_cap
    rxpri_len_cap #(.LEN_W(LEN_W), .SIZES(SIZES), .LIM_A(LIM_A), .LIM_B(LIM_B)) u_cap (
      .req_len(req_v[g]), .code(burst_code), .caps(burst_caps), .out_len(glen_v[g])
    );
  end

  rxpri_grant #(.LEN_W(LEN_W)) u_gnt (
    .clk    (clk), .rst(rst), .rx_prio(rx_prio),
    .rx_req (rx_req), .tx_req(tx_req),
    .rx_glen(glen_v[1]), .tx_glen(glen_v[0]),
    .beat   (beat), .gnt_rx(gnt_rx), .gnt_tx(gnt_tx), .gnt_len(gnt_len)
  );
endmodule

// File: rtl/rxpri_bus_arb_chk.sv
module rxpri_bus_arb_chk #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 11,
  parameter int LIM_A = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             thr_en,
  input logic [2:0]       hi_mark,
  input logic [2:0]       lo_mark,
  input logic [LVL_W-1:0] fill_level,
  input logic [1:0]       burst_code,
  input logic             rx_req,
  input logic             beat,
  input logic             gnt_rx,
  input logic             gnt_tx,
  input logic [LEN_W-1:0] gnt_len,
  input logic             rx_prio
);
  int unsigned hi_w, lo_w, fl_w;
  always_comb begin
    hi_w = (int'(hi_mark) * DEPTH) / 8;
    lo_w = (int'(lo_mark) * DEPTH) / 8;
    fl_w = int'(fill_level);
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) !(gnt_rx && gnt_tx)); // R7
  AST_PRIO_SET: assert property (@(posedge clk) disable iff (rst) (thr_en && fl_w >= hi_w) |=> rx_prio); // R2
  AST_PRIO_CLR: assert property (@(posedge clk) disable iff (rst) (thr_en && fl_w <= lo_w && fl_w < hi_w) |=> !rx_prio); // R3
  AST_PRIO_OFF: assert property (@(posedge clk) disable iff (rst) !thr_en |=> !rx_prio); // R4
  AST_RX_HELD: assert property (@(posedge clk) disable iff (rst) (gnt_rx && !beat) |=> (gnt_rx && $stable(gnt_len))); // R7
  AST_TX_HELD: assert property (@(posedge clk) disable iff (rst) (gnt_tx && !beat) |=> (gnt_tx && $stable(gnt_len))); // R7
  AST_PRIO_WIN: assert property (@(posedge clk) disable iff (rst) $rose(gnt_tx) |-> !($past(rx_prio) && $past(rx_req))); // R5
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (rst) ($rose(gnt_rx || gnt_tx) && $past(burst_code) == 2'd2) |-> (gnt_len <= LEN_W'(LIM_A) && gnt_len != '0)); // R8
  AST_IDLE_LEN: assert property (@(posedge clk) disable iff (rst) !(gnt_rx || gnt_tx) |-> gnt_len == '0); // R10
endmodule

bind rxpri_bus_arb rxpri_bus_arb_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W), .LIM_A(LIM_A), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .thr_en(thr_en), .hi_mark(hi_mark), .lo_mark(lo_mark),
  .fill_level(fill_level), .burst_code(burst_code), .rx_req(rx_req), .beat(beat),
  .gnt_rx(gnt_rx), .gnt_tx(gnt_tx), .gnt_len(gnt_len), .rx_prio(rx_prio)
);

// File: tb/rxpri_bus_arb_test.sv
module rxpri_bus_arb_test;
  localparam int DEPTH = 64;
  localparam int LEN_W = 11;
  localparam int SIZES = 3;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic thr_en = 1'b1;
  logic [2:0] hi_mark = 3'd6, lo_mark = 3'd2;
  logic [LVL_W-1:0] fill_level = '0;
  logic [1:0] burst_code = 2'd0;
  logic [SIZES-1:0] burst_caps = '0;
  logic rx_req = 1'b0, tx_req = 1'b0, beat = 1'b0;
  logic [LEN_W-1:0] rx_len = LEN_W'(4), tx_len = LEN_W'(4);
  logic gnt_rx, gnt_tx, rx_prio;
  logic [LEN_W-1:0] gnt_len;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rxpri_bus_arb #(.DEPTH(DEPTH), .LEN_W(LEN_W), .SIZES(SIZES)) uut (
    .clk(clk), .rst(rst), .thr_en(thr_en), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .fill_level(fill_level), .burst_code(burst_code), .burst_caps(burst_caps),
    .rx_req(rx_req), .rx_len(rx_len), .tx_req(tx_req), .tx_len(tx_len), .beat(beat),
    .gnt_rx(gnt_rx), .gnt_tx(gnt_tx), .gnt_len(gnt_len), .rx_prio(rx_prio)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_burst(int n, string req);
    beat = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) check("R7", "grant still held before last beat", int'(gnt_rx | gnt_tx), 1);
      tick();
    end
    beat = 1'b0;
    check(req, "grant released after last beat", int'(gnt_rx | gnt_tx), 0);
    check("R10", "length zero when idle", int'(gnt_len), 0);
  endtask

  task automatic t_reset();
    check("R1", "gnt_rx", int'(gnt_rx), 0);
    check("R1", "gnt_tx", int'(gnt_tx), 0);
    check("R1", "gnt_len", int'(gnt_len), 0);
    check("R1", "rx_prio", int'(rx_prio), 0);
  endtask

  task automatic t_hysteresis();
    fill_level = LVL_W'(47); tick();
    check("R2", "prio below high bound", int'(rx_prio), 0);
    fill_level = LVL_W'(48); tick();
    check("R2", "prio at high bound", int'(rx_prio), 1);
    fill_level = LVL_W'(30); tick();
    check("R3", "prio held between bounds", int'(rx_prio), 1);
    fill_level = LVL_W'(17); tick();
    check("R3", "prio held just above low bound", int'(rx_prio), 1);
    fill_level = LVL_W'(16); tick();
    check("R3", "prio cleared at low bound", int'(rx_prio), 0);
    fill_level = LVL_W'(30); tick();
    check("R3", "prio stays low between bounds", int'(rx_prio), 0);
  endtask

  task automatic t_enable();
    fill_level = LVL_W'(60); thr_en = 1'b0; tick();
    check("R4", "prio off while disabled", int'(rx_prio), 0);
    thr_en = 1'b1; tick();
    check("R4", "prio back on after enable", int'(rx_prio), 1);
    fill_level = '0; tick();
    check("R3", "prio cleared at empty", int'(rx_prio), 0);
  endtask

  task automatic t_round_robin();
    rx_req = 1'b1; tx_req = 1'b1; rx_len = LEN_W'(4); tx_len = LEN_W'(4);
    tick();
    check("R6", "first tie goes to receive", int'(gnt_rx), 1);
    check("R8", "unlimited length passed", int'(gnt_len), 4);
    finish_burst(4, "R10");
    tick();
    check("R6", "second tie goes to transmit", int'(gnt_tx), 1);
    finish_burst(4, "R10");
    rx_len = LEN_W'(2);
    tick();
    check("R6", "third tie back to receive", int'(gnt_rx), 1);
    check("R6", "receive length", int'(gnt_len), 2);
    rx_req = 1'b0; tx_req = 1'b0;
    finish_burst(2, "R10");
  endtask

  task automatic t_priority();
    fill_level = LVL_W'(50); tick();
    check("R2", "prio raised", int'(rx_prio), 1);
    rx_req = 1'b1; tx_req = 1'b1; rx_len = LEN_W'(4);
    tick();
    check("R5", "receive wins under pressure though it won last", int'(gnt_rx), 1);
    rx_req = 1'b0; tx_req = 1'b0;
    finish_burst(4, "R10");
    fill_level = '0; tick(); tick();
    tx_req = 1'b1; tx_len = LEN_W'(4); tick();
    check("R6", "lone transmit request served", int'(gnt_tx), 1);
    tx_req = 1'b0; rx_req = 1'b1; fill_level = LVL_W'(60);
    tick(); tick();
    check("R7", "pressure does not pre-empt transmit", int'(gnt_tx), 1);
    check("R7", "no receive grant during transmit", int'(gnt_rx), 0);
    rx_req = 1'b0;
    finish_burst(4, "R7");
    fill_level = '0; tick(); tick();
  endtask

  task automatic lim_case(logic [1:0] code, logic [SIZES-1:0] caps, int len, int exp, string req);
    burst_code = code; burst_caps = caps; tx_len = LEN_W'(len); tx_req = 1'b1;
    tick();
    check(req, $sformatf("granted length code=%0d caps=%0d req=%0d", code, caps, len), int'(gnt_len), exp);
    tx_req = 1'b0;
    finish_burst(exp, "R10");
  endtask

  task automatic t_limits();
    lim_case(2'd2, 3'b000, 100, 32, "R8");
    lim_case(2'd3, 3'b000, 100, 64, "R8");
    lim_case(2'd1, 3'b000, 100, 100, "R8");
    lim_case(2'd0, 3'b000, 100, 100, "R8");
    lim_case(2'd0, 3'b111, 13, 8, "R9");
    lim_case(2'd0, 3'b111, 20, 16, "R9");
    lim_case(2'd0, 3'b111, 3, 1, "R9");
    lim_case(2'd2, 3'b001, 100, 4, "R9");
    lim_case(2'd0, 3'b000, 0, 1, "R10");
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst = 1'b0;
    tick();
    t_reset();
    t_hysteresis();
    t_enable();
    t_round_robin();
    t_priority();
    t_limits();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule